// File: doc/BRIEF.md
# Gated Divided Clock-Enable Multiplexer Bank

This block drives a bank of clock-enable outputs from three source enable streams. Everything runs in one system clock domain. Each source arrives as a stream of single-cycle enable pulses. Each output has a 2-bit select field that picks one of the three sources or gates the output off. The output then divides the chosen stream through a 5-bit divider. That divider belongs to the pair formed by the chosen source and this output.

A flat register port sets up the block. Two select words hold the packed select fields. A field that falls past bit 31 of the first word continues in the second word. One divider word exists for each source/output pair. One read-only feedback word per source shows which outputs are running on that source. A switch is confirmed once the matching feedback bit goes high.

Top module: `ckdiv_mux_bank`

## Requirements
- R1: After reset every select field reads 3 (off). Select word 0 (address 0) reads 0xFFFFFF00 and select word 1 (address 1) reads 0x0000000F, for the default 14 outputs with fields starting at bit 8. Every divider reads 0, every feedback word reads 0, and no output pulses.
- R2: The field of output n occupies bits SEL_START+2n and SEL_START+2n+1 of the 64-bit image {word 1, word 0}. Fields past bit 31 continue in word 1 at (position minus 32). A read of either select word returns exactly the value last written.
- R3: An output whose select field is 3 produces no pulses, whatever the sources do.
- R4: Select values 0, 1 and 2 connect source 0, 1 and 2. A selected output reacts only to pulses of its own source.
- R5: With active divider value d, an output pulses once for every d+1 pulses of its selected source. The output pulse is high for one cycle, in the cycle after the source pulse that completes the count.
- R6: Each source/output pair has its own divider at address 64 + 16*source + output. The divider in force is the one belonging to the currently selected source.
- R7: A write that changes an output's select value restarts that output's count. So does any write to the divider of its currently selected source. The change takes effect from the next cycle.
- R8: Feedback word s (address 4+s) has bit FB_START+n (FB_START = 4) set exactly when output n is running on source s. The bit rises with the first output pulse after a switch. It clears when the select value changes, and all other bits read 0.
- R9: A divider word reads back the low 5 bits of the written value, with the upper bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 3 | One enable pulse stream per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| out_pulse | output | 14 | Divided enable pulse per output |

## Verification
Suppose a select field is decoded at the wrong bit position, most likely for the outputs whose fields spill into the second word. The wrong output then counts pulses from a source it was never given, and the discrepancy appears in the per-output pulse totals within one stream. A divider counter left uncleared by a switch shows up as an early or late first pulse, within d+1 source pulses. A stale running flag shows as a feedback bit that is still set right after a select write.

// File: rtl/ckdm_pkg.sv
package ckdm_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 7;
  localparam logic [ADDR_W-1:0] A_SEL_LO  = 7'd0;
  localparam logic [ADDR_W-1:0] A_SEL_HI  = 7'd1;
  localparam logic [ADDR_W-1:0] A_FB_BASE = 7'd4;
  localparam logic [1:0] SEL_OFF = 2'd3;

  // Reset image of the two select words: every field parked at off.
  function automatic logic [2*WORD_W-1:0] sel_reset_image(int unsigned start, int unsigned nout);
    logic [2*WORD_W-1:0] img;
    img = '0;
    for (int unsigned n = 0; n < nout; n++) img[start+2*n +: 2] = SEL_OFF;
    return img;
  endfunction

  // Divider word address of a source/output pair.
  function automatic logic [ADDR_W-1:0] div_addr(int unsigned s, int unsigned n);
    return {1'b1, s[1:0], n[3:0]};
  endfunction

  // Feedback word address of a source.
  function automatic logic [ADDR_W-1:0] fb_addr(int unsigned s);
    return A_FB_BASE + s[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/ckdm_regs.sv
module ckdm_regs
  import ckdm_pkg::*;
#(
  parameter int unsigned N_OUT     = 14,
  parameter int unsigned N_SRC     = 3,
  parameter int unsigned DIV_W     = 5,
  parameter int unsigned SEL_START = 8,
  parameter int unsigned FB_START  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [WORD_W-1:0]              wdata,
  input  logic [N_OUT-1:0]               run_vec,
  output logic [N_OUT-1:0][1:0]          sel_vec,
  output logic [N_OUT-1:0][DIV_W-1:0]    div_act,
  output logic [N_OUT-1:0]               sel_chg,
  output logic [N_OUT-1:0]               div_chg,
  output logic [N_SRC-1:0][WORD_W-1:0]   fb_words,
  output logic [WORD_W-1:0]              rdata
);
  localparam logic [2*WORD_W-1:0] SEL_RST = sel_reset_image(SEL_START, N_OUT);

  logic [2*WORD_W-1:0] sel_img_q, sel_img_nx;
  logic [DIV_W-1:0]    div_q [N_SRC][N_OUT];

  always_comb begin
    sel_img_nx = sel_img_q;
    if (we && addr == A_SEL_LO) sel_img_nx[WORD_W-1:0] = wdata;
    if (we && addr == A_SEL_HI) sel_img_nx[2*WORD_W-1:WORD_W] = wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel_img_q <= SEL_RST;
    else        sel_img_q <= sel_img_nx;
  end

  always_ff @(posedge clk) begin
    for (int unsigned s = 0; s < N_SRC; s++) begin
      for (int unsigned n = 0; n < N_OUT; n++) begin
        if (!rst_n) div_q[s][n] <= '0;
        else if (we && addr == div_addr(s, n)) div_q[s][n] <= wdata[DIV_W-1:0];
      end
    end
  end

  for (genvar n = 0; n < N_OUT; n++) begin : g_field
    assign sel_vec[n] = sel_img_q[SEL_START+2*n +: 2];
    assign sel_chg[n] = sel_img_nx[SEL_START+2*n +: 2] != sel_img_q[SEL_START+2*n +: 2];

    always_comb begin
      div_act[n] = '0;
      div_chg[n] = 1'b0;
      for (int unsigned s = 0; s < N_SRC; s++) begin
        if (32'(sel_vec[n]) == s) begin
          div_act[n] = div_q[s][n];
          div_chg[n] = we && (addr == div_addr(s, n));
        end
      end
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_fb
    always_comb begin
      fb_words[s] = '0;
      for (int unsigned n = 0; n < N_OUT; n++)
        fb_words[s][FB_START+n] = run_vec[n] && (32'(sel_vec[n]) == s);
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_SEL_LO) rdata = sel_img_q[WORD_W-1:0];
    if (addr == A_SEL_HI) rdata = sel_img_q[2*WORD_W-1:WORD_W];
    for (int unsigned s = 0; s < N_SRC; s++) begin
      if (addr == fb_addr(s)) rdata = fb_words[s];
      for (int unsigned n = 0; n < N_OUT; n++)
        if (addr == div_addr(s, n)) rdata = WORD_W'(div_q[s][n]);
    end
  end
endmodule

// File: rtl/ckdm_lane.sv
module ckdm_lane #(
  parameter int unsigned N_SRC = 3,
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] src_pulse,
  input  logic [1:0]       sel,
  input  logic [DIV_W-1:0] div_val,
  input  logic             clr_cnt,
  input  logic             clr_run,
  output logic             tick,
  output logic             running
);
  logic [DIV_W-1:0] cnt_q;
  logic             src_hit;

  // A count of d selected pulses plus the current one completes a period.
  function automatic logic period_done(logic [DIV_W-1:0] c, logic [DIV_W-1:0] d);
    return c >= d;
  endfunction

  always_comb begin
    src_hit = 1'b0;
    for (int unsigned s = 0; s < N_SRC; s++)
      if (32'(sel) == s) src_hit = src_pulse[s];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tick    <= 1'b0;
      running <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (clr_run) running <= 1'b0;
      if (clr_cnt) begin
        cnt_q <= '0;
      end else if (src_hit) begin
        if (period_done(cnt_q, div_val)) begin
          cnt_q   <= '0;
          tick    <= 1'b1;
          running <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ckdiv_mux_bank.sv
module ckdiv_mux_bank
  import ckdm_pkg::*;
#(
  parameter int unsigned N_OUT     = 14,
  parameter int unsigned N_SRC     = 3,
  parameter int unsigned DIV_W     = 5,
  parameter int unsigned SEL_START = 8,
  parameter int unsigned FB_START  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  src_pulse,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [N_OUT-1:0]  out_pulse
);
  logic [N_OUT-1:0][1:0]        sel_vec;
  logic [N_OUT-1:0][DIV_W-1:0]  div_act;
  logic [N_OUT-1:0]             sel_chg;
  logic [N_OUT-1:0]             div_chg;
  logic [N_OUT-1:0]             clr_cnt;
  logic [N_OUT-1:0]             run_vec;
  logic [N_SRC-1:0][WORD_W-1:0] fb_words;

  ckdm_regs #(
    .N_OUT(N_OUT), .N_SRC(N_SRC), .DIV_W(DIV_W),
    .SEL_START(SEL_START), .FB_START(FB_START)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .run_vec(run_vec), .sel_vec(sel_vec), .div_act(div_act),
    .sel_chg(sel_chg), .div_chg(div_chg), .fb_words(fb_words), .rdata(reg_rdata)
  );

  assign clr_cnt = sel_chg | div_chg;

  for (genvar n = 0; n < N_OUT; n++) begin : g_lane
    ckdm_lane #(.N_SRC(N_SRC), .DIV_W(DIV_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
      .sel(sel_vec[n]), .div_val(div_act[n]),
      .clr_cnt(clr_cnt[n]), .clr_run(sel_chg[n]),
      .tick(out_pulse[n]), .running(run_vec[n])
    );
  end
endmodule

// File: rtl/ckdm_chk.sv
module ckdm_chk #(
  parameter int unsigned N_OUT    = 14,
  parameter int unsigned N_SRC    = 3,
  parameter int unsigned FB_START = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_SRC-1:0]       src_pulse,
  input logic [N_OUT-1:0]       out_pulse,
  input logic [N_OUT-1:0][1:0]  sel_vec,
  input logic [N_OUT-1:0]       run_vec,
  input logic [N_OUT-1:0]       sel_chg,
  input logic [N_OUT-1:0]       clr_cnt,
  input logic [N_SRC-1:0][31:0] fb_words
);
  localparam logic [31:0] FB_MASK = ((32'd1 << N_OUT) - 32'd1) << FB_START;

  for (genvar n = 0; n < N_OUT; n++) begin : g_out
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_vec[n] == 2'd3) |=> !out_pulse[n]); // R3
    AST_TICK_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pulse == '0) |=> !out_pulse[n]); // R5
    AST_CLR_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cnt[n] |=> !out_pulse[n]); // R7
    AST_SWITCH_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      sel_chg[n] |=> !run_vec[n]); // R8
    AST_TICK_SETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      out_pulse[n] |-> run_vec[n]); // R8
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    AST_FB_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_words[s] & ~FB_MASK) == '0); // R8
  end
endmodule

bind ckdiv_mux_bank ckdm_chk #(.N_OUT(N_OUT), .N_SRC(N_SRC), .FB_START(FB_START)) chk_i (
  .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .out_pulse(out_pulse),
  .sel_vec(sel_vec), .run_vec(run_vec), .sel_chg(sel_chg), .clr_cnt(clr_cnt),
  .fb_words(fb_words)
);

// File: tb/ckdiv_mux_bank_tb_top.sv
module ckdiv_mux_bank_tb_top;
  localparam int NO = 14;
  localparam int NS = 3;
  localparam int SS = 8;
  localparam int FS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  src_pulse = '0;
  logic        reg_we = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NO-1:0] out_pulse;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [1:0] bsel [NO];
  logic [1:0] cur_sel [NO];
  logic [4:0] bdiv [NS][NO];
  bit         brun [NO];
  int         ticks [NO];
  int         scnt [NS];
  bit         cnt_en = 0;

  always #5 clk = ~clk;

  ckdiv_mux_bank dut_i (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .out_pulse(out_pulse)
  );

  always @(negedge clk)
    if (cnt_en)
      for (int n = 0; n < NO; n++) ticks[n] += int'(out_pulse[n]);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] daddr(int s, int n);
    return 7'(64 + 16 * s + n);
  endfunction

  function automatic logic [63:0] sel_image();
    logic [63:0] img = '0;
    for (int n = 0; n < NO; n++) img[SS + 2 * n +: 2] = bsel[n];
    return img;
  endfunction

  function automatic int exp_ticks(int n);
    if (bsel[n] == 2'd3) return 0;
    return scnt[bsel[n]] / (int'(bdiv[bsel[n]][n]) + 1);
  endfunction

  function automatic logic [31:0] exp_fb(int s);
    logic [31:0] w = '0;
    for (int n = 0; n < NO; n++) w[FS + n] = brun[n] && (int'(bsel[n]) == s);
    return w;
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic put_sel();
    logic [63:0] img = sel_image();
    for (int n = 0; n < NO; n++) begin
      if (bsel[n] != cur_sel[n]) brun[n] = 0;
      cur_sel[n] = bsel[n];
    end
    wr(7'd0, img[31:0]);
    wr(7'd1, img[63:32]);
  endtask

  task automatic put_div(input int s, input int n, input logic [4:0] d);
    bdiv[s][n] = d;
    wr(daddr(s, n), {27'd0, d});
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk);
    src_pulse = 3'(1 << s);
    @(negedge clk);
    src_pulse = '0;
  endtask

  task automatic stream(input int cycles);
    for (int s = 0; s < NS; s++) scnt[s] = 0;
    for (int n = 0; n < NO; n++) ticks[n] = 0;
    cnt_en = 1;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      src_pulse = 3'($urandom & 32'h7);
      for (int s = 0; s < NS; s++) scnt[s] += int'(src_pulse[s]);
    end
    @(negedge clk);
    src_pulse = '0;
    @(negedge clk);
    @(negedge clk);
    cnt_en = 0;
    for (int n = 0; n < NO; n++) if (ticks[n] > 0) brun[n] = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20231));
    for (int n = 0; n < NO; n++) begin
      bsel[n] = 2'd3; cur_sel[n] = 2'd3; brun[n] = 0;
      for (int s = 0; s < NS; s++) bdiv[s][n] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(7'd0, v); chk("R1 sel word0", v, 32'hFFFF_FF00);
    rd(7'd1, v); chk("R1 sel word1", v, 32'h0000_000F);
    rd(daddr(2, 13), v); chk("R1 divider", v, 32'h0);
    for (int s = 0; s < NS; s++) begin rd(7'(4 + s), v); chk("R1 feedback", v, 32'h0); end
    chk("R1 no pulse", 32'(out_pulse), 32'h0);

    // R3 all outputs off
    stream(40);
    v = 0; for (int n = 0; n < NO; n++) v += 32'(ticks[n]);
    chk("R3 off outputs silent", v, 32'h0);

    // R2 spill into the second select word
    bsel[12] = 2'd2; bsel[13] = 2'd1;
    put_sel();
    rd(7'd1, v); chk("R2 word1 readback", v, 32'h6);
    rd(7'd0, v); chk("R2 word0 readback", v, 32'hFFFF_FF00);
    stream(60);
    chk("R2 out12 from src2", 32'(ticks[12]), 32'(exp_ticks(12)));
    chk("R2 out13 from src1", 32'(ticks[13]), 32'(exp_ticks(13)));
    chk("R3 out0 still silent", 32'(ticks[0]), 32'h0);

    // R5 divide by 3, timing of the output pulse
    bsel[12] = 2'd3; bsel[13] = 2'd3; bsel[0] = 2'd0;
    put_sel();
    put_div(0, 0, 5'd2);
    pulse_src(0); chk("R5 no pulse after 1", 32'(out_pulse[0]), 32'h0);
    pulse_src(0); chk("R5 no pulse after 2", 32'(out_pulse[0]), 32'h0);
    rd(7'd4, v); chk("R8 not running yet", v, 32'h0);
    pulse_src(0); chk("R5 pulse after 3", 32'(out_pulse[0]), 32'h1);
    rd(7'd4, v); chk("R8 running on src0", v, 32'h10);
    @(negedge clk); chk("R5 single-cycle pulse", 32'(out_pulse[0]), 32'h0);

    // R6 per-source divider, R4 source isolation, R8 switch feedback
    put_div(1, 0, 5'd4);
    bsel[0] = 2'd1;
    put_sel();
    rd(7'd4, v); chk("R8 src0 bit cleared on switch", v, 32'h0);
    rd(7'd5, v); chk("R8 src1 bit low before pulse", v, 32'h0);
    for (int k = 0; k < 3; k++) pulse_src(0);
    chk("R4 other source ignored", 32'(out_pulse[0]), 32'h0);
    for (int k = 0; k < 4; k++) pulse_src(1);
    chk("R6 no pulse after 4 of 5", 32'(out_pulse[0]), 32'h0);
    pulse_src(1); chk("R6 pulse after 5", 32'(out_pulse[0]), 32'h1);
    rd(7'd5, v); chk("R8 running on src1", v, 32'h10);

    // R7 writing the active divider restarts the count
    for (int k = 0; k < 3; k++) pulse_src(1);
    put_div(1, 0, 5'd4);
    for (int k = 0; k < 4; k++) begin
      pulse_src(1);
      chk("R7 count restarted", 32'(out_pulse[0]), 32'h0);
    end
    pulse_src(1); chk("R7 pulse after full period", 32'(out_pulse[0]), 32'h1);

    // R9 divider width
    wr(daddr(2, 5), 32'hFF);
    rd(daddr(2, 5), v); chk("R9 divider readback", v, 32'h1F);
    bdiv[2][5] = 5'h1F;

    // Random configurations
    for (int r = 0; r < 12; r++) begin
      logic [63:0] img;
      for (int n = 0; n < NO; n++) bsel[n] = 2'($urandom_range(0, 3));
      put_sel();
      for (int s = 0; s < NS; s++)
        for (int n = 0; n < NO; n++) put_div(s, n, 5'($urandom_range(0, 12)));
      img = sel_image();
      rd(7'd0, v); chk("R2 random word0", v, img[31:0]);
      rd(7'd1, v); chk("R2 random word1", v, img[63:32]);
      rd(daddr(r % NS, r), v); chk("R9 random divider", v, 32'(bdiv[r % NS][r]));
      stream(300);
      for (int n = 0; n < NO; n++)
        chk((bsel[n] == 2'd3) ? "R3 random off" : "R5 R6 random count",
            32'(ticks[n]), 32'(exp_ticks(n)));
      for (int s = 0; s < NS; s++) begin
        rd(7'(4 + s), v); chk("R8 random feedback", v, exp_fb(s));
      end
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule